// File: doc/BRIEF.md
# UART Interrupt Status Encoder

This block gathers the seven interrupt conditions of a UART into one prioritized status byte and a single interrupt request line. The sources are receiver line status, received data at the FIFO trigger, receive time-out, transmit holding register empty, modem status change, Xoff or special character detection, and CTS/RTS change. Each source has a pending latch with its own set event and its own service strobe. A per-source enable can mask each one. The two enhanced sources are further gated by an enhanced-feature enable.

A status read presents only the code of the highest-priority enabled pending source. A lower source shows up only after the higher one has been serviced and the status is read again. The upper two status bits show whether the FIFOs are enabled. The block also decodes the 2-bit transmit trigger selection into a byte count, which the transmit-ready logic uses. FIFO storage, framing, baud generation and character matching lie outside the block. It only receives their detection pulses and levels.

Top module: `uirq_status_top`

## Requirements
- R1: After reset no source is pending: status reads 0x01 with FIFOs disabled, and irq_o is 0.
- R2: Status bits 5:0 carry the code of the highest-priority enabled pending source. The order from highest to lowest is: line status 0x06, receive time-out 0x0C / received data 0x04, transmit empty 0x02, modem 0x00, Xoff/special 0x10, CTS/RTS 0x20.
- R3: Received data and receive time-out share one priority level. When both are pending, time-out (0x0C) is shown.
- R4: When nothing enabled is pending, bits 5:0 read 0x01 and irq_o is 0. Otherwise bit 0 is 0 and irq_o is 1.
- R5: Status bits 7:6 equal 2'b11 when fifo_en_i is 1, and 2'b00 otherwise.
- R6: The Xoff/special source (code 0x10) and the CTS/RTS source (code 0x20) are visible only while enh_en_i is 1.
- R7: Once an Xoff/special detection pulse has arrived, that source stays pending until an Xon pulse. Status reads do not clear it.
- R8: Each source has its own clear:
  - line status clears on lsr_rd_i;
  - received data follows rx_trig_i, one clock later;
  - time-out clears on rx_rd_i;
  - modem status clears on msr_rd_i.
- R9: Transmit empty clears on thr_wr_i, or on an isr_rd_i cycle in which the status showed 0x02. A status read that showed another code leaves it pending.
- R10: A source whose src_en_i bit is 0 (bit index 0 line status, 1 data, 2 time-out, 3 transmit, 4 modem, 5 Xoff, 6 CTS/RTS) affects neither the status code nor irq_o.
- R11: When a source's set event and its clear arrive in the same cycle, the source is pending afterwards.
- R12: tx_trig_lvl_o gives the transmit trigger in bytes for txlvl_sel_i values 0, 1, 2 and 3: 16, 8, 24 and 30.
- R13: The CTS/RTS source clears on an isr_rd_i cycle in which the status showed 0x20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_en_i | input | 1 | FIFOs enabled |
| enh_en_i | input | 1 | Enhanced-feature enable |
| src_en_i | input | 7 | Per-source enables |
| lsr_evt_i | input | 1 | Line status error event |
| lsr_rd_i | input | 1 | Line status register read |
| rx_trig_i | input | 1 | Receive FIFO at or above trigger (level) |
| tmo_evt_i | input | 1 | Receive time-out event |
| rx_rd_i | input | 1 | Receive data read |
| thr_evt_i | input | 1 | Transmit holding empty event |
| thr_wr_i | input | 1 | Transmit holding register write |
| msr_evt_i | input | 1 | Modem status change event |
| msr_rd_i | input | 1 | Modem status register read |
| xoff_det_i | input | 1 | Xoff or special character detected |
| xon_det_i | input | 1 | Xon character detected |
| flow_evt_i | input | 1 | CTS/RTS change event |
| isr_rd_i | input | 1 | Status register read strobe |
| txlvl_sel_i | input | 2 | Transmit trigger selection |
| isr_o | output | 8 | Interrupt status byte |
| irq_o | output | 1 | Interrupt request |
| tx_trig_lvl_o | output | 5 | Transmit trigger level in bytes |

## Verification
Two things can fall in the same cycle: a source's new set event and its service strobe. The bench provokes this by pulsing the transmit-empty event together with a holding-register write, and the Xoff detection together with an Xon. It expects the source to remain visible in the status byte afterwards. It also issues a status read while line status masks transmit empty. The read must clear only the code it returned, so transmit empty must appear once line status is serviced.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int CODE_W = 6;
  localparam int STAT_W = CODE_W + 2;
  localparam int NSRC   = 7;

  localparam int SRC_LSR  = 0;
  localparam int SRC_RXD  = 1;
  localparam int SRC_TMO  = 2;
  localparam int SRC_THR  = 3;
  localparam int SRC_MSR  = 4;
  localparam int SRC_XOFF = 5;
  localparam int SRC_FLOW = 6;

  localparam logic [CODE_W-1:0] CODE_NONE = CODE_W'(6'h01);

  // status code for each source index
  function automatic logic [CODE_W-1:0] src_code(input int idx);
    case (idx)
      SRC_LSR:  return CODE_W'(6'h06);
      SRC_RXD:  return CODE_W'(6'h04);
      SRC_TMO:  return CODE_W'(6'h0C);
      SRC_THR:  return CODE_W'(6'h02);
      SRC_MSR:  return CODE_W'(6'h00);
      SRC_XOFF: return CODE_W'(6'h10);
      SRC_FLOW: return CODE_W'(6'h20);
      default:  return CODE_NONE;
    endcase
  endfunction

  // rank k (0 = highest priority) to source index; time-out outranks data
  function automatic int prio_slot(input int k);
    case (k)
      0:       return SRC_LSR;
      1:       return SRC_TMO;
      2:       return SRC_RXD;
      3:       return SRC_THR;
      4:       return SRC_MSR;
      5:       return SRC_XOFF;
      default: return SRC_FLOW;
    endcase
  endfunction

  // transmit trigger selection to byte count
  function automatic int tx_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 16;
      2'd1:    return 8;
      2'd2:    return 24;
      default: return 30;
    endcase
  endfunction
endpackage

// File: rtl/uirq_pend.sv
module uirq_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  // set has precedence over clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend_o <= 1'b0;
    else if (set_i) pend_o <= 1'b1;
    else if (clr_i) pend_o <= 1'b0;
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !clr_i) |=> pend_o);

  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> pend_o);
endmodule

// File: rtl/uirq_prio.sv
module uirq_prio
  import uirq_pkg::*;
(
  input  logic [NSRC-1:0]   act_i,
  output logic [NSRC-1:0]   win_o,
  output logic [CODE_W-1:0] code_o,
  output logic              any_o
);
  always_comb begin
    win_o  = '0;
    code_o = CODE_NONE;
    for (int k = NSRC - 1; k >= 0; k--) begin
      if (act_i[prio_slot(k)]) begin
        win_o              = '0;
        win_o[prio_slot(k)] = 1'b1;
        code_o             = src_code(prio_slot(k));
      end
    end
  end

  assign any_o = |act_i;
endmodule

// File: rtl/uirq_txlvl.sv
module uirq_txlvl #(
  parameter int LVL_W = 5
) (
  input  logic [1:0]       sel_i,
  output logic [LVL_W-1:0] lvl_o
);
  import uirq_pkg::*;
  assign lvl_o = LVL_W'(tx_level(sel_i));
endmodule

// File: rtl/uirq_status_top.sv
module uirq_status_top
  import uirq_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_en_i,
  input  logic              enh_en_i,
  input  logic [NSRC-1:0]   src_en_i,
  input  logic              lsr_evt_i,
  input  logic              lsr_rd_i,
  input  logic              rx_trig_i,
  input  logic              tmo_evt_i,
  input  logic              rx_rd_i,
  input  logic              thr_evt_i,
  input  logic              thr_wr_i,
  input  logic              msr_evt_i,
  input  logic              msr_rd_i,
  input  logic              xoff_det_i,
  input  logic              xon_det_i,
  input  logic              flow_evt_i,
  input  logic              isr_rd_i,
  input  logic [1:0]        txlvl_sel_i,
  output logic [STAT_W-1:0] isr_o,
  output logic              irq_o,
  output logic [LVL_W-1:0]  tx_trig_lvl_o
);
  logic [NSRC-1:0]   set_v;
  logic [NSRC-1:0]   clr_v;
  logic [NSRC-1:0]   pend_v;
  logic [NSRC-1:0]   gate_v;
  logic [NSRC-1:0]   act_v;
  logic [NSRC-1:0]   win_v;
  logic [CODE_W-1:0] cur_code;
  logic              any_act;
  logic              rd_hit_thr;
  logic              rd_hit_flow;

  // a status read services only the source whose code it returned
  assign rd_hit_thr  = isr_rd_i && win_v[SRC_THR];
  assign rd_hit_flow = isr_rd_i && win_v[SRC_FLOW];

  assign set_v[SRC_LSR]  = lsr_evt_i;
  assign clr_v[SRC_LSR]  = lsr_rd_i;
  assign set_v[SRC_RXD]  = rx_trig_i;
  assign clr_v[SRC_RXD]  = ~rx_trig_i;
  assign set_v[SRC_TMO]  = tmo_evt_i;
  assign clr_v[SRC_TMO]  = rx_rd_i;
  assign set_v[SRC_THR]  = thr_evt_i;
  assign clr_v[SRC_THR]  = thr_wr_i | rd_hit_thr;
  assign set_v[SRC_MSR]  = msr_evt_i;
  assign clr_v[SRC_MSR]  = msr_rd_i;
  assign set_v[SRC_XOFF] = xoff_det_i;
  assign clr_v[SRC_XOFF] = xon_det_i;
  assign set_v[SRC_FLOW] = flow_evt_i;
  assign clr_v[SRC_FLOW] = rd_hit_flow;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    uirq_pend u_pend (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_i  (set_v[i]),
      .clr_i  (clr_v[i]),
      .pend_o (pend_v[i])
    );
    if (i == SRC_XOFF || i == SRC_FLOW) begin : g_enh
      assign gate_v[i] = src_en_i[i] & enh_en_i;
    end else begin : g_std
      assign gate_v[i] = src_en_i[i];
    end
  end

  assign act_v = pend_v & gate_v;

  uirq_prio u_prio (
    .act_i  (act_v),
    .win_o  (win_v),
    .code_o (cur_code),
    .any_o  (any_act)
  );

  uirq_txlvl #(.LVL_W(LVL_W)) u_txlvl (
    .sel_i (txlvl_sel_i),
    .lvl_o (tx_trig_lvl_o)
  );

  assign isr_o = {{2{fifo_en_i}}, cur_code};
  assign irq_o = any_act;

  p_prio_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v[SRC_LSR] && src_en_i[SRC_LSR]) |-> isr_o[CODE_W-1:0] == CODE_W'(6'h06));

  p_tie_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v[SRC_TMO] && src_en_i[SRC_TMO]) |-> isr_o[CODE_W-1:0] != CODE_W'(6'h04));

  p_bit0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == !isr_o[0]);

  p_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
    isr_o[STAT_W-1:STAT_W-2] == {2{fifo_en_i}});

  p_enh_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !enh_en_i |-> isr_o[5:4] == 2'b00);

  p_thr_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_rd_i && isr_o[CODE_W-1:0] == CODE_W'(6'h02) && !thr_evt_i)
      |=> !pend_v[SRC_THR]);

  p_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !src_en_i[SRC_MSR] |-> isr_o[CODE_W-1:0] != CODE_W'(6'h00));

  p_lvl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_trig_lvl_o == LVL_W'(8) || tx_trig_lvl_o == LVL_W'(16) ||
    tx_trig_lvl_o == LVL_W'(24) || tx_trig_lvl_o == LVL_W'(30));

  p_flow_clr_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (isr_rd_i && isr_o[CODE_W-1:0] == CODE_W'(6'h20) && !flow_evt_i)
      |=> !pend_v[SRC_FLOW]);
endmodule

// File: tb/sim_uirq_status_top.sv
module sim_uirq_status_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_en_i = 1'b0, enh_en_i = 1'b0;
  logic [6:0] src_en_i = 7'h7F;
  logic       lsr_evt_i = 0, lsr_rd_i = 0, rx_trig_i = 0, tmo_evt_i = 0, rx_rd_i = 0;
  logic       thr_evt_i = 0, thr_wr_i = 0, msr_evt_i = 0, msr_rd_i = 0;
  logic       xoff_det_i = 0, xon_det_i = 0, flow_evt_i = 0, isr_rd_i = 0;
  logic [1:0] txlvl_sel_i = 2'd0;
  logic [7:0] isr_o;
  logic       irq_o;
  logic [4:0] tx_trig_lvl_o;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  uirq_status_top u0 (
    .clk(clk), .rst_n(rst_n), .fifo_en_i(fifo_en_i), .enh_en_i(enh_en_i),
    .src_en_i(src_en_i), .lsr_evt_i(lsr_evt_i), .lsr_rd_i(lsr_rd_i),
    .rx_trig_i(rx_trig_i), .tmo_evt_i(tmo_evt_i), .rx_rd_i(rx_rd_i),
    .thr_evt_i(thr_evt_i), .thr_wr_i(thr_wr_i), .msr_evt_i(msr_evt_i),
    .msr_rd_i(msr_rd_i), .xoff_det_i(xoff_det_i), .xon_det_i(xon_det_i),
    .flow_evt_i(flow_evt_i), .isr_rd_i(isr_rd_i), .txlvl_sel_i(txlvl_sel_i),
    .isr_o(isr_o), .irq_o(irq_o), .tx_trig_lvl_o(tx_trig_lvl_o)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  // expected byte: upper bits from fifo mode, low bits the code
  function automatic int stat(input int code);
    return (fifo_en_i ? 8'hC0 : 8'h00) | code;
  endfunction

  task automatic t_reset();
    chk("R1 status", isr_o, 8'h01);
    chk("R1 irq", irq_o, 0);
    fifo_en_i = 1; #1;
    chk("R5 fifo on idle", isr_o, 8'hC1);
    fifo_en_i = 0; #1;
  endtask

  task automatic t_priority();
    msr_evt_i = 1; thr_evt_i = 1; lsr_evt_i = 1;
    tick();
    msr_evt_i = 0; thr_evt_i = 0; lsr_evt_i = 0;
    chk("R2 line status first", isr_o, stat(8'h06));
    chk("R4 irq pending", irq_o, 1);
    fifo_en_i = 1; #1;
    chk("R5 fifo on pending", isr_o, 8'hC6);
    fifo_en_i = 0;
    lsr_rd_i = 1; tick(); lsr_rd_i = 0;
    chk("R8 line cleared, thr next", isr_o, stat(8'h02));
    thr_wr_i = 1; tick(); thr_wr_i = 0;
    chk("R9 thr cleared by write, modem next", isr_o, stat(8'h00));
    msr_rd_i = 1; tick(); msr_rd_i = 0;
    chk("R8 modem cleared", isr_o, stat(8'h01));
    chk("R4 irq idle", irq_o, 0);
  endtask

  task automatic t_tie();
    rx_trig_i = 1; tmo_evt_i = 1; tick(); tmo_evt_i = 0;
    chk("R3 time-out wins tie", isr_o, stat(8'h0C));
    rx_rd_i = 1; tick(); rx_rd_i = 0;
    chk("R8 time-out cleared, data shows", isr_o, stat(8'h04));
    rx_trig_i = 0; tick();
    chk("R8 data follows trigger", isr_o, stat(8'h01));
  endtask

  task automatic t_enh();
    enh_en_i = 0;
    xoff_det_i = 1; tick(); xoff_det_i = 0;
    chk("R6 xoff hidden", isr_o, stat(8'h01));
    chk("R6 irq hidden", irq_o, 0);
    enh_en_i = 1; #1;
    chk("R6 xoff visible", isr_o, stat(8'h10));
    isr_rd_i = 1; tick(); isr_rd_i = 0; tick();
    chk("R7 xoff held over read", isr_o, stat(8'h10));
    xon_det_i = 1; tick(); xon_det_i = 0;
    chk("R7 xon clears", isr_o, stat(8'h01));
    flow_evt_i = 1; tick(); flow_evt_i = 0;
    chk("R2 cts/rts code", isr_o, stat(8'h20));
    isr_rd_i = 1; tick(); isr_rd_i = 0;
    chk("R13 read clears cts/rts", isr_o, stat(8'h01));
  endtask

  task automatic t_mask();
    src_en_i[4] = 0;
    msr_evt_i = 1; tick(); msr_evt_i = 0;
    chk("R10 masked modem code", isr_o, stat(8'h01));
    chk("R10 masked modem irq", irq_o, 0);
    src_en_i[4] = 1; #1;
    chk("R10 unmasked modem", isr_o, stat(8'h00));
    msr_rd_i = 1; tick(); msr_rd_i = 0;
    chk("R8 modem read", isr_o, stat(8'h01));
  endtask

  task automatic t_thr_read();
    thr_evt_i = 1; lsr_evt_i = 1; tick(); thr_evt_i = 0; lsr_evt_i = 0;
    isr_rd_i = 1; tick(); isr_rd_i = 0;
    chk("R9 read of other code keeps thr", isr_o, stat(8'h06));
    lsr_rd_i = 1; tick(); lsr_rd_i = 0;
    chk("R9 thr visible", isr_o, stat(8'h02));
    isr_rd_i = 1; tick(); isr_rd_i = 0;
    chk("R9 read of thr code clears", isr_o, stat(8'h01));
  endtask

  task automatic t_same_cycle();
    thr_evt_i = 1; thr_wr_i = 1; tick(); thr_evt_i = 0; thr_wr_i = 0;
    chk("R11 thr set beats write", isr_o, stat(8'h02));
    thr_wr_i = 1; tick(); thr_wr_i = 0;
    chk("R11 thr then cleared", isr_o, stat(8'h01));
    xoff_det_i = 1; xon_det_i = 1; tick(); xoff_det_i = 0; xon_det_i = 0;
    chk("R11 xoff beats xon", isr_o, stat(8'h10));
    xon_det_i = 1; tick(); xon_det_i = 0;
    chk("R11 xoff then cleared", isr_o, stat(8'h01));
  endtask

  task automatic t_level();
    for (int s = 0; s < 4; s++) begin
      int exp;
      txlvl_sel_i = 2'(s); #1;
      exp = (s == 0) ? 16 : (s == 1) ? 8 : (s == 2) ? 24 : 30;
      chk("R12 tx trigger", tx_trig_lvl_o, exp);
    end
  endtask

  initial begin
    #600000;
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick();
    t_reset();
    t_priority();
    t_tie();
    t_enh();
    t_mask();
    t_thr_read();
    t_same_cycle();
    t_level();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule